// File: doc/BRIEF.md
# External Bus Address Break Monitor

This block watches a shared external bus during the periods when the local processor has handed the bus to another master. On every rising clock edge inside such a period it looks at the active-low bus-start strobe. When the strobe is low, it captures the 27-bit address and the read/write line of that cycle. It then compares them against a programmed break address, a per-bit address mask and an access-type selection. A match sets a sticky break interrupt request, which software clears by writing a one.

On multiplexed DRAM or SDRAM cycles the strobe falls with the column-address phase, so only that phase is evaluated. In that phase the bank-select bit and the auto-precharge bit carry control information rather than address bits. Software sets their mask bits so that they cannot spoil or force a match.

Top module: `ext_bus_brk_mon`

## Requirements
- R1: After a synchronous reset `brk_irq` is 0, the break address and mask are all zero, and the access-type field is 00, so no break can occur.
- R2: A bus cycle is evaluated only at an edge where `bus_released` is 1 and `bus_start_n` is 0. At any other edge `brk_irq` is left unchanged.
- R3: All 27 bits of `bus_addr` take part in the compare. The address matches when ((bus_addr XOR break address) AND NOT mask) is zero.
- R4: A mask bit of 1 removes that address bit from the compare, so a difference in that bit neither prevents nor causes a match.
- R5: The access-type field (register 2, bits 1:0) selects which cycles can match: 00 none, 01 reads only, 10 writes only, 11 both. `bus_read` = 1 marks a read and 0 marks a write.
- R6: `brk_irq` rises at the clock edge that follows the sampling edge of a matching cycle, and not at the sampling edge itself.
- R7: `brk_irq` stays set until a register write to index 3 with data bit 0 equal to 1. A write to index 3 with bit 0 equal to 0 has no effect.
- R8: When a match and a clear land on the same edge, the match wins and `brk_irq` stays 1.
- R9: Register writes are selected by `cfg_sel`: 0 is the break address (bits 26:0), 1 is the mask (bits 26:0) and 2 is the access type (bits 1:0). Each write takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| bus_released | input | 1 | 1 while another master owns the external bus |
| bus_start_n | input | 1 | Active-low bus-start strobe |
| bus_addr | input | 27 | External address lines 26..0 |
| bus_read | input | 1 | 1 = read cycle, 0 = write cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register index (0 address, 1 mask, 2 type, 3 clear) |
| cfg_wdata | input | 27 | Register write data |
| brk_irq | output | 1 | Sticky break interrupt request |

## Verification
The checker tests the following properties on every cycle:
- A rising `brk_irq` is always preceded by a qualified sample: bus released and strobe low, two edges back.
- A rising `brk_irq` never occurs while the access type is 00.
- A comparator hit always sets the flag on the next edge, even when a clear arrives on the same edge.
- A clear with no hit always drops the flag.
- The flag never falls without a clear.

The arithmetic of the masked address compare, the read/write selection, and the exact edge on which the flag first shows can only be seen in the bench's scenarios. Those scenarios compare `brk_irq` against a model of the masked compare, both in directed corner cases and with random addresses close to the break address.

// File: rtl/abm_pkg.sv
package abm_pkg;
  localparam int ADDR_W = 27;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_ANY   = 2'b11
  } acc_t;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_MASK = 2'd1,
    SEL_TYPE = 2'd2,
    SEL_CLR  = 2'd3
  } sel_t;
endpackage

// File: rtl/abm_cfg_regs.sv
module abm_cfg_regs #(
  parameter int AW = abm_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] brk_addr,
  output logic [AW-1:0] brk_mask,
  output abm_pkg::acc_t acc_type,
  output logic          clr_pulse
);
  import abm_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_addr <= '0;
      brk_mask <= '0;
      acc_type <= ACC_NONE;
    end else if (we) begin
      case (sel_t'(sel))
        SEL_ADDR: brk_addr <= wdata;
        SEL_MASK: brk_mask <= wdata;
        SEL_TYPE: acc_type <= acc_t'(wdata[1:0]);
        default:  ;
      endcase
    end
  end

  // clear request is a pulse; the flag module resolves priority
  assign clr_pulse = we && (sel_t'(sel) == SEL_CLR) && wdata[0];
endmodule

// File: rtl/abm_bus_capture.sv
module abm_bus_capture #(
  parameter int AW = abm_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          released,
  input  logic          start_n,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  output logic          cap_valid,
  output logic [AW-1:0] cap_addr,
  output logic          cap_rd
);
  logic qual;
  assign qual = released & ~start_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_rd    <= 1'b0;
    end else begin
      cap_valid <= qual;
      if (qual) begin
        cap_addr <= addr;
        cap_rd   <= rd;
      end
    end
  end
endmodule

// File: rtl/abm_match.sv
module abm_match #(
  parameter int AW = abm_pkg::ADDR_W
) (
  input  logic          cap_valid,
  input  logic [AW-1:0] cap_addr,
  input  logic          cap_rd,
  input  logic [AW-1:0] brk_addr,
  input  logic [AW-1:0] brk_mask,
  input  abm_pkg::acc_t acc_type,
  output logic          hit
);
  import abm_pkg::*;

  logic [AW-1:0] bit_ok;
  logic          addr_ok;
  logic          type_ok;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = brk_mask[i] | ~(cap_addr[i] ^ brk_addr[i]);
  end

  assign addr_ok = &bit_ok;

  always_comb begin
    case (acc_type)
      ACC_READ:  type_ok = cap_rd;
      ACC_WRITE: type_ok = ~cap_rd;
      ACC_ANY:   type_ok = 1'b1;
      default:   type_ok = 1'b0;
    endcase
  end

  assign hit = cap_valid & addr_ok & type_ok;
endmodule

// File: rtl/abm_irq_flag.sv
module abm_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/ext_bus_brk_mon.sv
module ext_bus_brk_mon #(
  parameter int AW = abm_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_released,
  input  logic          bus_start_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_read,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          brk_irq
);
  logic [AW-1:0] brk_addr, brk_mask, cap_addr;
  abm_pkg::acc_t acc_type;
  logic          clr_pulse, cap_valid, cap_rd, cmp_hit;

  abm_cfg_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .brk_addr(brk_addr), .brk_mask(brk_mask), .acc_type(acc_type),
    .clr_pulse(clr_pulse)
  );

  abm_bus_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst), .released(bus_released), .start_n(bus_start_n),
    .addr(bus_addr), .rd(bus_read),
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_rd(cap_rd)
  );

  abm_match #(.AW(AW)) u_match (
    .cap_valid(cap_valid), .cap_addr(cap_addr), .cap_rd(cap_rd),
    .brk_addr(brk_addr), .brk_mask(brk_mask), .acc_type(acc_type),
    .hit(cmp_hit)
  );

  abm_irq_flag u_flag (
    .clk(clk), .rst(rst), .set_i(cmp_hit), .clr_i(clr_pulse), .flag(brk_irq)
  );
endmodule

// File: rtl/abm_checker.sv
module abm_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_released,
  input logic       bus_start_n,
  input logic       clr_req,
  input logic       hit,
  input logic [1:0] acc_type,
  input logic       brk_irq
);
  logic qual_d1;
  always_ff @(posedge clk) begin
    if (rst) qual_d1 <= 1'b0;
    else     qual_d1 <= bus_released & ~bus_start_n;
  end

  // R2 and R6: a rise must come from a qualified sample two edges earlier
  assert_rise_needs_sample_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_irq) |-> $past(qual_d1));

  // R5: access type 00 never breaks
  assert_none_type_silent_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_irq) |-> ($past(acc_type) != 2'b00));

  // R8: a hit sets the flag even with a clear on the same edge
  assert_hit_wins_R8: assert property (@(posedge clk) disable iff (rst)
    hit |=> brk_irq);

  // R7: a clear without a hit drops the flag
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !hit) |=> !brk_irq);

  // R7: the flag is sticky without a clear
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (brk_irq && !clr_req) |=> brk_irq);
endmodule

bind ext_bus_brk_mon abm_checker chk_i (
  .clk(clk), .rst(rst), .bus_released(bus_released), .bus_start_n(bus_start_n),
  .clr_req(clr_pulse), .hit(cmp_hit), .acc_type(acc_type), .brk_irq(brk_irq)
);

// File: tb/ext_bus_brk_mon_tb_top.sv
module ext_bus_brk_mon_tb_top;
  localparam int AW = 27;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_released, bus_start_n, bus_read;
  logic [AW-1:0] bus_addr;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [AW-1:0] cfg_wdata;
  logic          brk_irq;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_addr, m_mask;
  logic [1:0]    m_type;
  logic          m_flag;

  always #2.5 clk = ~clk;

  ext_bus_brk_mon dut_i (
    .clk(clk), .rst(rst), .bus_released(bus_released), .bus_start_n(bus_start_n),
    .bus_addr(bus_addr), .bus_read(bus_read), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .brk_irq(brk_irq)
  );

  function automatic logic exp_hit(logic rel, logic sn, logic [AW-1:0] a, logic rd);
    logic tok;
    case (m_type)
      2'b01:   tok = rd;
      2'b10:   tok = !rd;
      2'b11:   tok = 1'b1;
      default: tok = 1'b0;
    endcase
    return rel && !sn && tok && (((a ^ m_addr) & ~m_mask) == '0);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: brk_irq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_bus();
    bus_released = 1'b0; bus_start_n = 1'b1; bus_addr = '0; bus_read = 1'b0;
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      2'd0: m_addr = d;
      2'd1: m_mask = d;
      2'd2: m_type = d[1:0];
      default: if (d[0]) m_flag = 1'b0;
    endcase
  endtask

  task automatic clear_flag(string req);
    cfg_write(2'd3, 27'd1);
    check(req, brk_irq, 1'b0);
  endtask

  // one bus sample: checks the flag is unchanged at the sampling edge and updated one edge later
  task automatic bus_cycle(string req, logic rel, logic sn, logic [AW-1:0] a, logic rd);
    logic h;
    @(negedge clk);
    bus_released = rel; bus_start_n = sn; bus_addr = a; bus_read = rd;
    h = exp_hit(rel, sn, a, rd);
    @(negedge clk);
    idle_bus();
    check({req, "/R6-early"}, brk_irq, m_flag);
    @(negedge clk);
    m_flag = m_flag | h;
    check(req, brk_irq, m_flag);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog: expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_bus();
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    m_addr = '0; m_mask = '0; m_type = 2'b00; m_flag = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state, flag low and type 00 blocks a zero-address match
    check("R1", brk_irq, 1'b0);
    bus_cycle("R1", 1'b1, 1'b0, '0, 1'b1);

    // R9: program registers
    cfg_write(2'd0, 27'h5A5_A5A5);
    cfg_write(2'd1, 27'h0);
    cfg_write(2'd2, 27'd3);
    // R2: not released, or strobe high: no evaluation
    bus_cycle("R2", 1'b0, 1'b0, 27'h5A5_A5A5, 1'b1);
    bus_cycle("R2", 1'b1, 1'b1, 27'h5A5_A5A5, 1'b1);
    // R3: top and bottom bit differences block the match
    bus_cycle("R3", 1'b1, 1'b0, 27'h5A5_A5A5 ^ 27'h400_0000, 1'b1);
    bus_cycle("R3", 1'b1, 1'b0, 27'h5A5_A5A5 ^ 27'h1, 1'b0);
    bus_cycle("R3", 1'b1, 1'b0, 27'h5A5_A5A5, 1'b1);
    // R7: sticky, a write of 0 to index 3 does nothing, then clear
    bus_cycle("R7", 1'b0, 1'b1, '0, 1'b0);
    cfg_write(2'd3, 27'd0);
    check("R7", brk_irq, 1'b1);
    clear_flag("R7");
    // R4: mask two bits (bank and auto-precharge positions)
    cfg_write(2'd1, 27'h000_0C00);
    bus_cycle("R4", 1'b1, 1'b0, 27'h5A5_A5A5 ^ 27'h000_0C00, 1'b0);
    clear_flag("R4");
    bus_cycle("R4", 1'b1, 1'b0, 27'h5A5_A5A5 ^ 27'h000_1000, 1'b0);
    // R5: read only / write only / none
    cfg_write(2'd2, 27'd1);
    bus_cycle("R5", 1'b1, 1'b0, 27'h5A5_A5A5, 1'b0);
    bus_cycle("R5", 1'b1, 1'b0, 27'h5A5_A5A5, 1'b1);
    clear_flag("R5");
    cfg_write(2'd2, 27'd2);
    bus_cycle("R5", 1'b1, 1'b0, 27'h5A5_A5A5, 1'b1);
    bus_cycle("R5", 1'b1, 1'b0, 27'h5A5_A5A5, 1'b0);
    clear_flag("R5");
    cfg_write(2'd2, 27'd0);
    bus_cycle("R5", 1'b1, 1'b0, 27'h5A5_A5A5, 1'b0);

    // R8: hit and clear on the same edge
    cfg_write(2'd2, 27'd3);
    @(negedge clk);
    bus_released = 1'b1; bus_start_n = 1'b0; bus_addr = 27'h5A5_A5A5; bus_read = 1'b1;
    @(negedge clk);
    idle_bus();
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 27'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_flag = 1'b1;
    check("R8", brk_irq, 1'b1);
    clear_flag("R8");

    // random mix: R3 R4 R5 R2
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) begin
        cfg_write(2'd0, 27'($urandom));
        cfg_write(2'd1, 27'($urandom) & 27'($urandom) & 27'($urandom));
        cfg_write(2'd2, 27'($urandom % 4));
      end
      begin
        logic [AW-1:0] a;
        a = ($urandom % 2) ? (m_addr ^ (27'($urandom) & m_mask)) : 27'($urandom);
        if ($urandom % 4 == 0) a = a ^ (27'd1 << ($urandom % AW));
        bus_cycle("R3/R4/R5 random", ($urandom % 4) != 0, ($urandom % 4) == 0,
                  a, 1'($urandom));
      end
      if (m_flag && ($urandom % 3 == 0)) clear_flag("R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule